// File: doc/BRIEF.md
# Conditional and Loop Sequencing Controller

This block sequences a condition step and one or two branch steps under a go/done handshake. The parent raises `go` and keeps it high until it observes `done`. The controller first starts the condition unit. When that unit finishes, the controller latches the one-bit result and then starts one of the following:

- In conditional mode, the true branch or the false branch.
- In loop mode, the body. After each body pass the controller evaluates the condition again.

Each child holds its done input high for one cycle when it finishes. A child request (`*_go`) stays high until the controller accepts that child's done, and the request falls at the next edge. `done` is a registered one-cycle pulse. All internal state is cleared in the same update that raises `done`, so the parent may lower `go` and later start a new pass.

Top module: `branch_ctrl`

## Requirements
- R1: After reset, `done`, `cond_go`, `then_go` and `else_go` are 0. While `go` is 0, no child request is raised.
- R2: A new pass starts with `cond_go` high in the first cycle that `go` is high. No branch or body request is raised until the condition unit's done has been accepted in the current pass. `cond_go` is never high together with `then_go` or `else_go`.
- R3: The branch decision uses the value of `cond_val` captured on the edge where the condition's done is accepted. Any later change on `cond_val` has no effect on which branch runs.
- R4: Mode is selected by `loop_mode`, where 0 is conditional and 1 is loop. In conditional mode, a captured 1 runs `then_go` once and a captured 0 runs `else_go` once; the other branch never starts.
- R5: In conditional mode, `done` is high in the cycle after the selected branch's done is accepted.
- R6: In loop mode, a captured 1 runs the body on `then_go`. When the body's done is accepted, the condition is evaluated again. `else_go` is never raised in loop mode.
- R7: In loop mode, a captured 0 ends the pass. `done` rises two cycles after that condition done, and no body starts. The body runs exactly as many times as the condition returned 1, which includes zero times when the first result is 0.
- R8: `done` lasts exactly one cycle. No child request is high while `done` is high.
- R9: A child done that arrives while its request is low is ignored and does not advance the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_mode | input | 1 | 0 conditional, 1 loop; held stable during a pass |
| go | input | 1 | Parent start, held until done is seen |
| done | output | 1 | One-cycle completion pulse |
| cond_go | output | 1 | Start request to the condition unit |
| cond_done | input | 1 | Condition unit finished (one cycle) |
| cond_val | input | 1 | Condition result, valid with cond_done |
| then_go | output | 1 | Start request to the true branch or loop body |
| then_done | input | 1 | True branch or body finished |
| else_go | output | 1 | Start request to the false branch |
| else_done | input | 1 | False branch finished |

## Verification
The bench targets several specific failure modes:

- **Unlatched decision.** Right after each condition handshake the bench inverts `cond_val`. A design that routes the live port into the branch choice would switch branches midway, or leave a loop early.
- **Loop bookkeeping.** Sweeps of zero to four loop iterations catch a loop that never clears its condition-complete flag (one body run, then a hang or a repeat), an off-by-one exit, and a body started on a false first result.
- **Stray done pulses.** Done pulses are injected while the controller is idle. A controller that accepted them would skip the condition step on the next start.
- **Handshake overlap.** Varying child latencies, including zero, expose any overlap between the condition request and a branch request.

// File: rtl/branch_ctrl.sv
module branch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_mode,
  input  logic go,
  output logic done,
  output logic cond_go,
  input  logic cond_done,
  input  logic cond_val,
  output logic then_go,
  input  logic then_done,
  output logic else_go,
  input  logic else_done
);

  logic cond_seen;
  logic cond_bit;
  logic done_q;

  logic active, cond_fin, then_fin, else_fin, loop_exit, finish;

  assign active    = go & ~done_q;
  assign cond_go   = active & ~cond_seen;
  assign then_go   = active & cond_seen & cond_bit;
  assign else_go   = active & cond_seen & ~cond_bit & ~loop_mode;
  assign done      = done_q;

  assign cond_fin  = cond_go & cond_done;
  assign then_fin  = then_go & then_done;
  assign else_fin  = else_go & else_done;
  assign loop_exit = active & cond_seen & ~cond_bit & loop_mode;
  assign finish    = loop_mode ? loop_exit : (then_fin | else_fin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_seen <= 1'b0;
      cond_bit  <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        cond_seen <= 1'b0;
        cond_bit  <= 1'b0;
      end else if (cond_fin) begin
        cond_seen <= 1'b1;
        cond_bit  <= cond_val;
      end else if (loop_mode && then_fin) begin
        cond_seen <= 1'b0;
        cond_bit  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/branch_ctrl_chk.sv
module branch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic loop_mode,
  input logic go,
  input logic done,
  input logic cond_go,
  input logic cond_done,
  input logic cond_val,
  input logic then_go,
  input logic then_done,
  input logic else_go,
  input logic else_done
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !(cond_go || then_go || else_go));

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cond_go && (then_go || else_go)));

  // R6
  loop_no_else_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> !else_go);

  // R5
  if_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_mode && then_go && then_done) |=> done);

  // R5
  if_else_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_mode && else_go && else_done) |=> done);

  // R7
  loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && loop_mode && cond_go && cond_done && !cond_val) |=> (!then_go ##1 done));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(cond_go || then_go || else_go));

endmodule

bind branch_ctrl branch_ctrl_chk u_chk (.*);

// File: tb/branch_ctrl_bench.sv
module branch_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_mode = 1'b0;
  logic go = 1'b0;
  logic done, cond_go, then_go, else_go;
  logic cd_resp = 1'b0, td_resp = 1'b0, ed_resp = 1'b0, stray = 1'b0;
  logic cond_val = 1'b0;
  logic cond_done, then_done, else_done;

  assign cond_done = cd_resp | stray;
  assign then_done = td_resp | stray;
  assign else_done = ed_resp | stray;

  always #4 clk = ~clk;

  branch_ctrl u_branch_ctrl (
    .clk(clk), .rst_n(rst_n), .loop_mode(loop_mode), .go(go), .done(done),
    .cond_go(cond_go), .cond_done(cond_done), .cond_val(cond_val),
    .then_go(then_go), .then_done(then_done),
    .else_go(else_go), .else_done(else_done));

  int compared = 0, mismatched = 0;
  int lat_c = 0, lat_b = 0;
  int n_ones = 0;
  logic if_val = 1'b0;
  int cond_cnt = 0, then_cnt = 0, else_cnt = 0;
  int overlap_errs = 0;
  int cycles = 0;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cond_go && (then_go || else_go)) overlap_errs++;
    if (rst_n && loop_mode && else_go) overlap_errs++;
  end

  initial begin : cond_unit
    logic v;
    forever begin
      @(posedge clk); #2;
      if (cond_go) begin
        repeat (lat_c) begin @(posedge clk); #2; end
        v = loop_mode ? (cond_cnt < n_ones) : if_val;
        cond_cnt++;
        cond_val = v;
        cd_resp = 1'b1;
        @(posedge clk); #2;
        cd_resp = 1'b0;
        cond_val = ~v;
      end
    end
  end

  initial begin : then_unit
    forever begin
      @(posedge clk); #2;
      if (then_go) begin
        repeat (lat_b) begin @(posedge clk); #2; end
        then_cnt++;
        td_resp = 1'b1;
        @(posedge clk); #2;
        td_resp = 1'b0;
      end
    end
  end

  initial begin : else_unit
    forever begin
      @(posedge clk); #2;
      if (else_go) begin
        repeat (lat_b) begin @(posedge clk); #2; end
        else_cnt++;
        ed_resp = 1'b1;
        @(posedge clk); #2;
        ed_resp = 1'b0;
      end
    end
  end

  task automatic run_pass(input logic mode, input int ones, input logic iv,
                          input int lc, input int lb);
    int wait_cyc;
    loop_mode = mode; n_ones = ones; if_val = iv; lat_c = lc; lat_b = lb;
    cond_cnt = 0; then_cnt = 0; else_cnt = 0;
    @(negedge clk);
    go = 1'b1;
    #1;
    chk("R2 cond_go at start", int'(cond_go), 1);
    chk("R2 no branch at start", int'(then_go | else_go), 0);
    wait_cyc = 0;
    while (!done && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk("R8 done seen", int'(done), 1);
    chk("R8 quiet during done", int'(cond_go | then_go | else_go), 0);
    go = 1'b0;
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    if (mode) begin
      chk("R7 body count", then_cnt, ones);
      chk("R7 cond evaluations", cond_cnt, ones + 1);
      chk("R6 no else in loop", else_cnt, 0);
    end else begin
      chk("R4 then count", then_cnt, iv ? 1 : 0);
      chk("R4 else count", else_cnt, iv ? 0 : 1);
      chk("R3 single evaluation", cond_cnt, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done reset", int'(done), 0);
    chk("R1 go outputs reset", int'(cond_go | then_go | else_go), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle no requests", int'(cond_go | then_go | else_go), 0);

    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk("R9 stray done ignored", int'(done), 0);
    run_pass(1'b0, 0, 1'b1, 0, 0);

    for (int v = 0; v < 2; v++)
      for (int lc = 0; lc < 3; lc++)
        for (int lb = 0; lb < 3; lb++)
          run_pass(1'b0, 0, v[0], lc, lb);

    for (int n = 0; n < 5; n++)
      for (int lc = 0; lc < 3; lc++)
        for (int lb = 0; lb < 3; lb++)
          run_pass(1'b1, n, 1'b0, lc, lb);

    loop_mode = 1'b1;
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    chk("R9 stray in loop mode", int'(done), 0);
    run_pass(1'b1, 2, 1'b0, 1, 0);

    chk("R2 R6 overlap monitor", overlap_errs, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule